// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a running time of day for packet timestamping. The time has three parts: 48 bits of seconds, 30 bits of nanoseconds and a 24-bit fraction of a nanosecond. On every clock the counter adds a programmed whole-nanosecond step and a programmed fractional step. A carry out of the fraction adds one more nanosecond. When the nanoseconds reach one billion they fold back and the seconds move on by one.

Software uses a small synchronous register port. It loads the time, programs both step sizes, applies one-shot signed corrections and reads the time back. The nominal step is the integer part of 1e9 divided by the clock rate. The fraction is the remainder, scaled by 2^24 and divided by the rate. A read of the lower seconds word freezes the nanoseconds and the upper seconds in shadow registers, so that a sequence of reads returns one coherent instant. The live seconds and nanoseconds also drive output ports for the timestamp logic next to the block.

Top module: `tod_counter`

## Requirements
- R1: After reset the seconds, nanoseconds, fraction, both step registers, both shadow registers and `rdata` are zero, so the counter stands still.
- R2: On a clock with no time load and no offset write, the fraction becomes (fraction + fractional step) mod 2^24. The nanoseconds gain the whole-nanosecond step plus the carry out of that fraction sum.
- R3: When the advanced nanosecond value is at least 1,000,000,000, one billion is subtracted and the seconds increase by one on the same clock.
- R4: With both step registers at zero and no write, the seconds and nanoseconds hold their values.
- R5: A write to address 0 loads seconds[47:32] from wdata[15:0]. A write to address 1 loads seconds[31:0] from wdata[31:0]. A write to address 2 loads the nanoseconds from wdata[29:0] and clears the fraction. On a load clock the counter does not advance, and the fields that are not written keep their values.
- R6: Address 3 holds the whole-nanosecond step in bits [7:0]. Address 4 holds the 24-bit fractional step with fraction bits [23:8] in register bits [15:0] and fraction bits [7:0] in register bits [31:24]. Both read back in the same layout. A new step takes effect from the clock after the write.
- R7: A write to address 5 applies a correction exactly once, on the write clock and in place of that clock's step; the fraction holds. Bit 31 = 0 adds and bit 31 = 1 subtracts the magnitude in wdata[29:0]. The result is brought back into [0, 1e9), and a sum of 1e9 or more moves the seconds up by one (two if it reaches 2e9).
- R8: A subtracting correction that takes the nanoseconds below zero borrows: it adds 1e9 and takes one second (2e9 and two seconds when the result is below -1e9).
- R9: rdata is registered and valid on the clock after rd_en. A read of address 1 returns the live seconds[31:0] and captures seconds[47:32] and the nanoseconds into shadows. Reads of address 0 and address 2 return those shadows, zero-extended. Address 5 reads as zero.
- R10: The seconds count modulo 2^48 in both directions: a carry from the all-ones value gives zero, and a borrow from zero gives the all-ones value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timestamp clock; the counter advances on every rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after rd_en |
| tod_sec | output | 48 | Live seconds |
| tod_ns | output | 30 | Live nanoseconds |

## Verification
The hardest cases to reach are the corrections that cross two seconds at once and the seconds wrap in both directions. A running counter changes too fast to set them up from its ports. The stimulus therefore first stops the counter by zeroing both steps. It then loads exact seconds and nanoseconds next to each boundary and issues the largest add and subtract magnitudes, so the results can be predicted by hand. The fractional carry is covered with a step whose low fraction byte is nonzero, which also tests the split register layout. Snapshot coherence is tested by reading the shadowed nanoseconds several clocks after the capture, while the live value has moved on.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SEC_W  = 48;
  localparam int NS_W   = 30;
  localparam int SUB_W  = 24;
  localparam int INC_W  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int SUB_LO = 8;
  localparam int HI_W   = SEC_W - DATA_W;
  localparam int ACC_W  = NS_W + 4;

  localparam logic [NS_W-1:0] NS_PER_S = NS_W'(1000000000);

  typedef logic [SEC_W-1:0] sec_t;
  typedef logic [NS_W-1:0]  ns_t;
  typedef logic [SUB_W-1:0] sub_t;
  typedef logic [INC_W-1:0] inc_t;

  typedef enum logic [ADDR_W-1:0] {
    RA_SEC_HI   = 3'd0,
    RA_SEC_LO   = 3'd1,
    RA_NSEC     = 3'd2,
    RA_STEP_NS  = 3'd3,
    RA_STEP_SUB = 3'd4,
    RA_OFFSET   = 3'd5
  } reg_addr_e;

  typedef struct packed {
    sec_t sec;
    ns_t  ns;
    sub_t sub;
    logic sub_carry;
    logic sec_carry;
  } tod_next_t;

  typedef struct packed {
    sec_t sec;
    ns_t  ns;
  } tod_pair_t;

  // One clock of advance: fraction, nanoseconds, single second carry.
  function automatic tod_next_t tod_tick(sec_t s, ns_t n, sub_t f, inc_t i, sub_t fi);
    logic [SUB_W:0] fs;
    logic [NS_W:0]  nsum;
    tod_next_t      r;
    fs   = {1'b0, f} + {1'b0, fi};
    nsum = {1'b0, n} + {{(NS_W+1-INC_W){1'b0}}, i} + {{NS_W{1'b0}}, fs[SUB_W]};
    r.sub       = fs[SUB_W-1:0];
    r.sub_carry = fs[SUB_W];
    if (nsum >= {1'b0, NS_PER_S}) begin
      r.ns        = NS_W'(nsum - {1'b0, NS_PER_S});
      r.sec       = s + sec_t'(1);
      r.sec_carry = 1'b1;
    end else begin
      r.ns        = nsum[NS_W-1:0];
      r.sec       = s;
      r.sec_carry = 1'b0;
    end
    return r;
  endfunction

  // Signed one-shot offset with up to two seconds of carry or borrow.
  function automatic tod_pair_t tod_adjust(sec_t s, ns_t n, logic neg, ns_t mag);
    logic signed [ACC_W-1:0] v;
    logic signed [ACC_W-1:0] one_s;
    logic signed [ACC_W-1:0] two_s;
    tod_pair_t r;
    one_s = $signed({4'b0, NS_PER_S});
    two_s = one_s + one_s;
    v = neg ? ($signed({4'b0, n}) - $signed({4'b0, mag}))
            : ($signed({4'b0, n}) + $signed({4'b0, mag}));
    r.sec = s;
    if (v >= two_s) begin
      v = v - two_s;  r.sec = s + sec_t'(2);
    end else if (v >= one_s) begin
      v = v - one_s;  r.sec = s + sec_t'(1);
    end else if (v < -one_s) begin
      v = v + two_s;  r.sec = s - sec_t'(2);
    end else if (v < 0) begin
      v = v + one_s;  r.sec = s - sec_t'(1);
    end
    r.ns = v[NS_W-1:0];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pack_sub(sub_t f);
    return {f[SUB_LO-1:0], {(DATA_W-SUB_W){1'b0}}, f[SUB_W-1:SUB_LO]};
  endfunction

  function automatic sub_t unpack_sub(logic [DATA_W-1:0] w);
    return {w[SUB_W-SUB_LO-1:0], w[DATA_W-1:DATA_W-SUB_LO]};
  endfunction
endpackage

// File: rtl/tod_regfile.sv
module tod_regfile
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  sec_t              cur_sec,
  input  ns_t               cur_ns,
  output logic [DATA_W-1:0] rdata,
  output logic              ld_hi,
  output logic              ld_lo,
  output logic              ld_ns,
  output logic              adj_req,
  output logic              adj_neg,
  output ns_t               adj_mag,
  output inc_t              step_ns,
  output sub_t              step_sub
);
  logic [HI_W-1:0] shadow_hi;
  ns_t             shadow_ns;
  reg_addr_e       ra;

  assign ra      = reg_addr_e'(addr);
  assign ld_hi   = wr_en && (ra == RA_SEC_HI);
  assign ld_lo   = wr_en && (ra == RA_SEC_LO);
  assign ld_ns   = wr_en && (ra == RA_NSEC);
  assign adj_req = wr_en && (ra == RA_OFFSET);
  assign adj_neg = wdata[DATA_W-1];
  assign adj_mag = wdata[NS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_ns  <= '0;
      step_sub <= '0;
    end else if (wr_en) begin
      if (ra == RA_STEP_NS)  step_ns  <= wdata[INC_W-1:0];
      if (ra == RA_STEP_SUB) step_sub <= unpack_sub(wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata     <= '0;
      shadow_hi <= '0;
      shadow_ns <= '0;
    end else if (rd_en) begin
      case (ra)
        RA_SEC_HI:   rdata <= DATA_W'(shadow_hi);
        RA_SEC_LO: begin
          rdata     <= cur_sec[DATA_W-1:0];
          shadow_hi <= cur_sec[SEC_W-1:DATA_W];
          shadow_ns <= cur_ns;
        end
        RA_NSEC:     rdata <= DATA_W'(shadow_ns);
        RA_STEP_NS:  rdata <= DATA_W'(step_ns);
        RA_STEP_SUB: rdata <= pack_sub(step_sub);
        default:     rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tod_core.sv
module tod_core
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              ld_ns,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              adj_req,
  input  logic              adj_neg,
  input  ns_t               adj_mag,
  input  inc_t              step_ns,
  input  sub_t              step_sub,
  output sec_t              sec_q,
  output ns_t               ns_q,
  output sub_t              sub_q,
  output logic              load_any,
  output logic              tick_en,
  output logic              sec_wrap,
  output logic              sub_carry
);
  tod_next_t nx_tick;
  tod_pair_t nx_adj;

  always_comb begin
    nx_tick = tod_tick(sec_q, ns_q, sub_q, step_ns, step_sub);
    nx_adj  = tod_adjust(sec_q, ns_q, adj_neg, adj_mag);
  end

  assign load_any  = ld_hi || ld_lo || ld_ns;
  assign tick_en   = !load_any && !adj_req;
  assign sec_wrap  = tick_en && nx_tick.sec_carry;
  assign sub_carry = tick_en && nx_tick.sub_carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
      sub_q <= '0;
    end else if (load_any) begin
      if (ld_hi) sec_q[SEC_W-1:DATA_W] <= ld_data[HI_W-1:0];
      if (ld_lo) sec_q[DATA_W-1:0]     <= ld_data;
      if (ld_ns) begin
        ns_q  <= ld_data[NS_W-1:0];
        sub_q <= '0;
      end
    end else if (adj_req) begin
      sec_q <= nx_adj.sec;
      ns_q  <= nx_adj.ns;
    end else begin
      sec_q <= nx_tick.sec;
      ns_q  <= nx_tick.ns;
      sub_q <= nx_tick.sub;
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [NS_W-1:0]   tod_ns
);
  logic ld_hi, ld_lo, ld_ns, adj_req, adj_neg;
  ns_t  adj_mag;
  inc_t step_ns;
  sub_t step_sub;
  sub_t sub_q;
  logic load_any, tick_en, sec_wrap, sub_carry;

  tod_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cur_sec(tod_sec), .cur_ns(tod_ns), .rdata(rdata),
    .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_ns(ld_ns), .adj_req(adj_req),
    .adj_neg(adj_neg), .adj_mag(adj_mag), .step_ns(step_ns), .step_sub(step_sub)
  );

  tod_core u_core (
    .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_ns(ld_ns),
    .ld_data(wdata), .adj_req(adj_req), .adj_neg(adj_neg), .adj_mag(adj_mag),
    .step_ns(step_ns), .step_sub(step_sub), .sec_q(tod_sec), .ns_q(tod_ns),
    .sub_q(sub_q), .load_any(load_any), .tick_en(tick_en),
    .sec_wrap(sec_wrap), .sub_carry(sub_carry)
  );
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
  import tod_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input sec_t              tod_sec,
  input ns_t               tod_ns,
  input inc_t              step_ns,
  input sub_t              step_sub,
  input logic              load_any,
  input logic              tick_en,
  input logic              sec_wrap,
  input logic              sub_carry
);
  p_ns_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_ns < NS_PER_S && !load_any) |=> tod_ns < NS_PER_S);

  p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |=> tod_sec == $past(tod_sec) + sec_t'(1));

  p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !sec_wrap) |=> tod_sec == $past(tod_sec));

  p_frac_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && sub_carry && !sec_wrap) |=>
      tod_ns == $past(tod_ns) + ns_t'($past(step_ns)) + ns_t'(1));

  p_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && step_ns == '0 && step_sub == '0) |=> ($stable(tod_ns) && $stable(tod_sec)));

  p_hi_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(RA_SEC_HI)) |=> $stable(tod_ns));

  p_offset_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(RA_OFFSET)) |-> !tick_en);
endmodule

bind tod_counter tod_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .tod_sec(tod_sec),
  .tod_ns(tod_ns), .step_ns(step_ns), .step_sub(step_sub), .load_any(load_any),
  .tick_en(tick_en), .sec_wrap(sec_wrap), .sub_carry(sub_carry)
);

// File: tb/sim_tod_counter.sv
module sim_tod_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  longint m_sec, m_ns, m_frac, m_inc, m_fsub, m_shhi, m_shns, m_rd;
  longint saved;
  localparam longint BILLION = 1000000000;
  localparam longint SMASK = 48'hFFFF_FFFF_FFFF;

  tod_counter u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tod_sec(tod_sec), .tod_ns(tod_ns));

  always #10 clk = ~clk;

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: advances on each rising edge from the applied inputs.
  task automatic m_step();
    m_frac = m_frac + m_fsub;
    m_ns   = m_ns + m_inc + (m_frac >> 24);
    m_frac = m_frac & 24'hFFFFFF;
    if (m_ns >= BILLION) begin m_ns -= BILLION; m_sec = (m_sec + 1) & SMASK; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_ns = 0; m_frac = 0; m_inc = 0; m_fsub = 0;
      m_shhi = 0; m_shns = 0; m_rd = 0;
    end else begin
      if (rd_en) begin
        case (addr)
          3'd0: m_rd = m_shhi;
          3'd1: begin m_rd = m_sec & 32'hFFFFFFFF; m_shhi = m_sec >> 32; m_shns = m_ns; end
          3'd2: m_rd = m_shns;
          3'd3: m_rd = m_inc;
          3'd4: m_rd = ((m_fsub & 255) << 24) | (m_fsub >> 8);
          default: m_rd = 0;
        endcase
      end
      if (wr_en && addr == 3'd0) m_sec = (m_sec & 32'hFFFFFFFF) | (longint'(wdata[15:0]) << 32);
      else if (wr_en && addr == 3'd1) m_sec = (m_sec & ~longint'(32'hFFFFFFFF)) | longint'(wdata);
      else if (wr_en && addr == 3'd2) begin m_ns = wdata[29:0]; m_frac = 0; end
      else if (wr_en && addr == 3'd5) begin
        longint v;
        v = wdata[31] ? m_ns - longint'(wdata[29:0]) : m_ns + longint'(wdata[29:0]);
        while (v >= BILLION) begin v -= BILLION; m_sec = (m_sec + 1) & SMASK; end
        while (v < 0)        begin v += BILLION; m_sec = (m_sec - 1) & SMASK; end
        m_ns = v;
      end else begin
        m_step();
        if (wr_en && addr == 3'd3) m_inc = wdata[7:0];
        if (wr_en && addr == 3'd4) m_fsub = {wdata[15:0], wdata[31:24]};
      end
    end
  end

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R3 sec", tod_sec, m_sec);
      chk("R2/R3 ns", tod_ns, m_ns);
      chk("R9 rdata", rdata, m_rd & 32'hFFFFFFFF);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sec", tod_sec, 0);
    chk("R1 ns", tod_ns, 0);
    chk("R1 rdata", rdata, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 idle ns", tod_ns, 0);
    rd(3'd3); chk("R1 step", rdata, 0);

    wr(3'd3, 32'd8);
    wr(3'd4, 32'h0000_8000);
    repeat (10) @(negedge clk);
    rd(3'd4); chk("R6 sub layout", rdata, 32'h0000_8000);
    rd(3'd3); chk("R6 ns step", rdata, 8);
    wr(3'd4, 32'hEF00_ABCD);
    rd(3'd4); chk("R6 split fraction", rdata, 32'hEF00_ABCD);
    repeat (30) @(negedge clk);
    chk("R2 ns vs model", tod_ns, m_ns);

    wr(3'd0, 32'h0000_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'd999_999_990);
    chk("R5 ns load", tod_ns, 999_999_990);
    chk("R5 sec load", tod_sec, 48'hFFFF_FFFF_FFFF);
    repeat (5) @(negedge clk);
    chk("R10 carry wrap", tod_sec, 0);
    chk("R3 rollover ns", tod_ns, m_ns);

    wr(3'd0, 32'h0000_1234);
    rd(3'd1);
    saved = m_shns;
    repeat (7) @(negedge clk);
    rd(3'd2); chk("R9 ns snapshot", rdata, saved);
    rd(3'd0); chk("R9 hi snapshot", rdata, 32'h1234);

    wr(3'd3, 32'd0);
    wr(3'd4, 32'd0);
    saved = tod_ns;
    repeat (6) @(negedge clk);
    chk("R4 stopped", tod_ns, saved);

    wr(3'd0, 32'd0);
    wr(3'd1, 32'd5);
    wr(3'd2, 32'd999_999_000);
    wr(3'd5, 32'h3FFF_FFFF);
    chk("R7 double carry sec", tod_sec, 7);
    chk("R7 double carry ns", tod_ns, 73_740_823);
    repeat (3) @(negedge clk);
    chk("R7 once", tod_ns, 73_740_823);
    wr(3'd2, 32'd100);
    wr(3'd5, 32'h8000_00C8);
    chk("R8 borrow sec", tod_sec, 6);
    chk("R8 borrow ns", tod_ns, 999_999_900);
    wr(3'd2, 32'd100);
    wr(3'd5, 32'hBFFF_FFFF);
    chk("R8 double borrow sec", tod_sec, 4);
    chk("R8 double borrow ns", tod_ns, 926_258_277);
    wr(3'd5, 32'd500);
    chk("R7 add", tod_ns, 926_258_777);
    rd(3'd5); chk("R9 offset reads zero", rdata, 0);

    wr(3'd1, 32'd0);
    wr(3'd2, 32'd50);
    wr(3'd5, 32'h8000_003C);
    chk("R10 borrow wrap sec", tod_sec, 48'hFFFF_FFFF_FFFF);
    chk("R10 borrow wrap ns", tod_ns, 999_999_990);

    wr(3'd3, 32'd3);
    wr(3'd4, 32'hFF00_FFFF);
    repeat (100) @(negedge clk);
    wr(3'd5, 32'h8000_1000);
    repeat (20) @(negedge clk);
    wr(3'd2, 32'd12345);
    chk("R5 load while running", tod_ns, 12345);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule